// File: doc/BRIEF.md
# Oversampling Bit Clock Recovery DPLL

This block recovers the bit timing of a hard-limited 1200 baud audio-demodulator output. A free-running sub-sample tick enable is counted down to schedule line samples. Each bit is sampled either three or two times, depending on the mode input. One sample of every bit, the decision sample, also steers the loop. If the recent transition history shows the line edge arriving late or early against the decision sample, the next sample interval is lengthened or shortened by exactly one tick. Intermediate samples never move the timing.

Decision samples are NRZI decoded: an unchanged level is a one and a changed level is a zero. The decoded bits are gathered least-significant first into 16-bit words, which a downstream HDLC deframer takes from a one-cycle strobe. A signed counter counts late corrections up and early corrections down, so the loop's drift can be watched. The mode input is expected to be held steady and changed only under reset. The line input is expected to be synchronous to the clock.

Top module: `bcr_dpll_top`

## Requirements
- R1: While reset is low and on the first cycle after it, word_valid is 0, word_data is 0 and corr_count is 0. Reset clears the transition history, the sample phase and both remembered line levels, and loads the nominal interval of the selected mode.
- R2: Only clock edges with tick_en high advance the sample timer. A sample is taken on the tick that ends the current interval. The nominal interval is 4 ticks when mode_two is 0 (three samples per bit) and 6 ticks when mode_two is 1 (two samples per bit).
- R3: The sample phase steps 0,1,2,0 when mode_two is 0 and 0,1,0 when mode_two is 1. Phase 0 is the decision sample, and the first sample after reset is a decision sample.
- R4: Every sample shifts one bit into the transition history. The bit is 1 when the sampled line differs from the previous sample, with the newest bit at position 0.
- R5: With mode_two at 0, a decision sample whose 3-bit history window (oldest to newest) reads 001 is late and makes the next interval 5 ticks. A window of 100 is early and makes the next interval 3 ticks.
- R6: With mode_two at 1, a decision sample whose 2-bit window reads 01 makes the next interval 7 ticks. A window of 10 makes it 5 ticks.
- R7: Intermediate samples always use the nominal interval and never change corr_count, whatever their history window shows.
- R8: A decoded data bit is 1 when the decision sample equals the previous decision sample and 0 otherwise.
- R9: The first decoded bit of a word lands in word_data bit 0. On the clock after the 16th decision sample of a word, word_valid is high for exactly one cycle with the new word.
- R10: corr_count is a CORR_W-bit two's-complement counter. It rises by 1 on each late correction and falls by 1 on each early correction, wrapping at its limits, and changes on no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Sub-sample tick enable |
| line_in | input | 1 | Hard-limited demodulated line level |
| mode_two | input | 1 | 0: three samples per bit, 1: two samples per bit |
| word_data | output | 16 | Recovered data word, first bit in bit 0 |
| word_valid | output | 1 | One-cycle strobe for word_data |
| corr_count | output | CORR_W (8) | Signed count of late minus early corrections |

## Verification
The bench places a single edge just before a decision sample and another just after one, in both modes. It then checks that the word strobe moves by exactly one tick in the expected direction. A design that swaps the late and early windows, or mixes up the two modes' interval tables, would put the strobe two ticks away from the expected tick and show the wrong counter sign. A known NRZI-encoded pattern has its edges ending each history window seen by an intermediate sample in the late-looking form. A design that corrects on every sample would drift and corrupt both words. Gated ticks, and a word's bit order checked against its first bit, catch a timer that counts raw clocks and a packer that reverses bits.

// File: rtl/bcr_pkg.sv
// Shared types for the bit clock recovery loop.
package bcr_pkg;
    // Verdict of the phase detector on one sample.
    typedef enum logic [1:0] {
        CORR_NONE  = 2'd0,
        CORR_LATE  = 2'd1,
        CORR_EARLY = 2'd2
    } corr_e;
endpackage

// File: rtl/bcr_interval_timer.sv
// Sample interval timer.
// Counts tick-qualified clocks and flags a sample on the tick that ends the
// current interval, then reloads with the interval chosen for the next one.
// Assumes mode_two is only changed while reset is low.
module bcr_interval_timer #(
    parameter int CNT_W = 4,
    parameter int NOM3  = 4,
    parameter int NOM2  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mode_two,
    input  logic [CNT_W-1:0] next_ivl,
    output logic             sample_evt
);
    localparam int IVL_MIN = NOM3 - 1;
    localparam int IVL_MAX = NOM2 + 1;

    logic [CNT_W-1:0] left_q;

    // A sample happens on the last tick of the interval.
    assign sample_evt = tick_en && (left_q == CNT_W'(1));

    // Count down ticks and reload on every sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= mode_two ? CNT_W'(NOM2) : CNT_W'(NOM3);
        end else if (tick_en) begin
            if (left_q == CNT_W'(1)) left_q <= next_ivl;
            else                     left_q <= left_q - CNT_W'(1);
        end
    end

    // R5 R6: any reloaded interval is the nominal one or one tick off it.
    p_ivl_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_evt |-> (int'(next_ivl) >= IVL_MIN && int'(next_ivl) <= IVL_MAX));

    // R2: the timer never runs dry.
    p_timer_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (left_q != '0));
endmodule

// File: rtl/bcr_phase_detect.sv
// Transition history, sample phase and early/late decision.
// On each sample it records whether the line moved since the previous
// sample. On decision samples it looks at a window of that history to pick
// the next interval and to update the correction counter.
// Assumes line_in is already synchronous to clk.
module bcr_phase_detect
    import bcr_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int NOM3   = 4,
    parameter int NOM2   = 6,
    parameter int HIST_W = 3,
    parameter int CORR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_two,
    input  logic              sample_evt,
    input  logic              line_in,
    output logic [CNT_W-1:0]  next_ivl,
    output logic              decide_evt,
    output logic [CORR_W-1:0] corr_count
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_next;
    logic              last_q;
    logic [1:0]        phase_q;
    logic [CORR_W-1:0] corr_q;
    corr_e             verdict;
    logic [CNT_W-1:0]  nominal;

    assign hist_next  = {hist_q[HIST_W-2:0], line_in ^ last_q};
    assign decide_evt = sample_evt && (phase_q == 2'd0);
    assign nominal    = mode_two ? CNT_W'(NOM2) : CNT_W'(NOM3);
    assign corr_count = corr_q;

    // Classify the history window; only a decision sample may correct.
    always_comb begin
        verdict = CORR_NONE;
        if (phase_q == 2'd0) begin
            if (mode_two) begin
                if (hist_next[1:0] == 2'b01)      verdict = CORR_LATE;
                else if (hist_next[1:0] == 2'b10) verdict = CORR_EARLY;
            end else begin
                if (hist_next[2:0] == 3'b001)      verdict = CORR_LATE;
                else if (hist_next[2:0] == 3'b100) verdict = CORR_EARLY;
            end
        end
    end

    // Interval for the span that follows this sample.
    always_comb begin
        case (verdict)
            CORR_LATE:  next_ivl = nominal + CNT_W'(1);
            CORR_EARLY: next_ivl = nominal - CNT_W'(1);
            default:    next_ivl = nominal;
        endcase
    end

    // Keep the history, the previous sample and the sample phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            last_q  <= 1'b0;
            phase_q <= 2'd0;
        end else if (sample_evt) begin
            hist_q <= hist_next;
            last_q <= line_in;
            if (mode_two)              phase_q <= (phase_q == 2'd0) ? 2'd1 : 2'd0;
            else if (phase_q == 2'd2)  phase_q <= 2'd0;
            else                       phase_q <= phase_q + 2'd1;
        end
    end

    // Count late corrections up and early ones down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q <= '0;
        end else if (sample_evt) begin
            if (verdict == CORR_LATE)       corr_q <= corr_q + CORR_W'(1);
            else if (verdict == CORR_EARLY) corr_q <= corr_q - CORR_W'(1);
        end
    end

    // R3: the phase stays inside the cycle of the selected mode.
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_two ? (phase_q <= 2'd1) : (phase_q <= 2'd2));

    // R10: the counter only moves on a sample edge.
    p_corr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_evt |=> $stable(corr_q));

    // R7: after an intermediate sample the counter has not moved.
    p_interm_nocorr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_evt && phase_q != 2'd0) |=> $stable(corr_q));
endmodule

// File: rtl/bcr_nrzi_packer.sv
// NRZI decoder and word packer.
// On each decision sample it turns "level unchanged" into 1 and "level
// changed" into 0, then shifts the bit into a register that carries a
// sentinel one above the data. When the sentinel reaches the bottom, the
// word is complete and is handed out with a one-cycle strobe.
module bcr_nrzi_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decide_evt,
    input  logic              line_in,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);
    localparam logic [WORD_W:0] SENTINEL = {1'b1, {WORD_W{1'b0}}};

    logic [WORD_W:0] sreg_q;
    logic [WORD_W:0] sreg_shift;
    logic            last_dec_q;
    logic            data_bit;

    assign data_bit   = (line_in == last_dec_q);
    assign sreg_shift = {data_bit, sreg_q[WORD_W:1]};

    // Decode, shift, and emit when the sentinel arrives at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q     <= SENTINEL;
            last_dec_q <= 1'b0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (decide_evt) begin
                last_dec_q <= line_in;
                if (sreg_shift[0]) begin
                    word_data  <= sreg_shift[WORD_W:1];
                    word_valid <= 1'b1;
                    sreg_q     <= SENTINEL;
                end else begin
                    sreg_q <= sreg_shift;
                end
            end
        end
    end

    // R9: the sentinel is never lost from the packing register.
    p_sentinel_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_q != '0);

    // R9: a word strobe lasts a single cycle.
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
endmodule

// File: rtl/bcr_dpll_top.sv
// Bit clock recovery loop, top level.
// Joins the interval timer, the phase detector and the NRZI packer.
// Assumes mode_two is static outside reset and line_in is synchronous.
module bcr_dpll_top #(
    parameter int WORD_W = 16,
    parameter int CORR_W = 8,
    parameter int NOM3   = 4,
    parameter int NOM2   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              line_in,
    input  logic              mode_two,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic [CORR_W-1:0] corr_count
);
    localparam int CNT_W  = $clog2(NOM2 + 2);
    localparam int HIST_W = 3;

    logic [CNT_W-1:0] next_ivl;
    logic             sample_evt;
    logic             decide_evt;

    bcr_interval_timer #(.CNT_W(CNT_W), .NOM3(NOM3), .NOM2(NOM2)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .mode_two   (mode_two),
        .next_ivl   (next_ivl),
        .sample_evt (sample_evt)
    );

    bcr_phase_detect #(
        .CNT_W(CNT_W), .NOM3(NOM3), .NOM2(NOM2),
        .HIST_W(HIST_W), .CORR_W(CORR_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_two   (mode_two),
        .sample_evt (sample_evt),
        .line_in    (line_in),
        .next_ivl   (next_ivl),
        .decide_evt (decide_evt),
        .corr_count (corr_count)
    );

    bcr_nrzi_packer #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .decide_evt (decide_evt),
        .line_in    (line_in),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    // R1: nothing is strobed on the first cycle out of reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !word_valid);
endmodule

// File: tb/sim_bcr_dpll_top.sv
module sim_bcr_dpll_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        line_in = 1'b0;
    logic        mode_two = 1'b0;
    logic [15:0] word_data;
    logic        word_valid;
    logic [7:0]  corr_count;

    int tests = 0;
    int fails = 0;
    int tick_cnt = 0;
    int wd = 0;
    int v1_tick, v2_tick, nvalid, probe_corr;
    logic [15:0] v1_word, v2_word;
    logic lvl_tab [0:32];

    always #4 clk = ~clk;

    bcr_dpll_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_in(line_in),
        .mode_two(mode_two), .word_data(word_data), .word_valid(word_valid),
        .corr_count(corr_count)
    );

    always @(posedge clk) begin
        if (!rst_n)       tick_cnt <= 0;
        else if (tick_en) tick_cnt <= tick_cnt + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog (all): actual=%0d cycles expected<150000", wd);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    function automatic logic lvl(input int kind, input int th, input int t);
        int seg;
        if (kind == 1) return (t >= th);
        if (kind == 2) begin
            seg = (t + 2) / 12;
            if (seg > 32) seg = 32;
            return lvl_tab[seg];
        end
        return 1'b0;
    endfunction

    task automatic do_reset(input logic two);
        mode_two = two;
        rst_n = 1'b0;
        tick_en = 1'b0;
        line_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic play(input int kind, input int th, input bit gate,
                        input int stop_tick, input int probe);
        int cyc = 0;
        nvalid = 0; v1_tick = -1; v2_tick = -1; v1_word = '0; v2_word = '0;
        probe_corr = 999;
        while (tick_cnt < stop_tick && cyc < 20000) begin
            tick_en = gate ? (cyc % 3 == 0) : 1'b1;
            line_in = lvl(kind, th, tick_cnt + 1);
            @(negedge clk);
            cyc++;
            if (word_valid) begin
                if (nvalid == 0) begin v1_tick = tick_cnt; v1_word = word_data; end
                else if (nvalid == 1) begin v2_tick = tick_cnt; v2_word = word_data; end
                nvalid++;
            end
            if (tick_cnt == probe) probe_corr = int'($signed(corr_count));
        end
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1", "valid after reset", int'(word_valid), 0);
        chk("R1", "word after reset", int'(word_data), 0);
        chk("R1", "corr after reset", int'(corr_count), 0);
    endtask

    // R2 R3 R8 R9: steady line, three samples per bit
    task automatic t_nominal3;
        do_reset(1'b0);
        play(0, 0, 1'b0, 200, -1);
        chk("R2", "first strobe tick, mode 3", v1_tick, 184);
        chk("R8", "steady line gives ones", int'(v1_word), 16'hFFFF);
        chk("R10", "no corrections, steady", int'($signed(corr_count)), 0);
    endtask

    // R7 R8 R9: NRZI words with edges seen only by intermediate samples
    task automatic t_nrzi;
        logic [31:0] data = {16'h3C5A, 16'hA5C3};
        logic prev = 1'b0;
        for (int k = 0; k < 32; k++) begin
            prev = data[k] ? prev : ~prev;
            lvl_tab[k] = prev;
        end
        lvl_tab[32] = prev;
        do_reset(1'b0);
        play(2, 0, 1'b0, 390, -1);
        chk("R9", "word1 value", int'(v1_word), 16'hA5C3);
        chk("R9", "word1 tick", v1_tick, 184);
        chk("R8", "word2 value", int'(v2_word), 16'h3C5A);
        chk("R9", "word2 tick", v2_tick, 376);
        chk("R7", "no correction from intermediates", int'($signed(corr_count)), 0);
    endtask

    // R5 R10: late edge in three-sample mode
    task automatic t_late3;
        do_reset(1'b0);
        play(1, 14, 1'b0, 200, 16);
        chk("R10", "corr after late", probe_corr, 1);
        chk("R5", "strobe delayed one tick", v1_tick, 185);
        chk("R8", "word after late edge", int'(v1_word), 16'hFFFD);
    endtask

    // R5 R10: early edge in three-sample mode
    task automatic t_early3;
        do_reset(1'b0);
        play(1, 18, 1'b0, 200, 28);
        chk("R10", "corr after early", probe_corr, -1);
        chk("R5", "strobe advanced one tick", v1_tick, 183);
        chk("R8", "word after early edge", int'(v1_word), 16'hFFFB);
    endtask

    // R2: ticks gated to one clock in three
    task automatic t_gated;
        do_reset(1'b0);
        play(0, 0, 1'b1, 200, -1);
        chk("R2", "gated ticks strobe tick", v1_tick, 184);
        chk("R2", "gated ticks word", int'(v1_word), 16'hFFFF);
    endtask

    // R2 R3: steady line, two samples per bit
    task automatic t_nominal2;
        do_reset(1'b1);
        play(0, 0, 1'b0, 200, -1);
        chk("R2", "first strobe tick, mode 2", v1_tick, 186);
        chk("R3", "mode 2 word", int'(v1_word), 16'hFFFF);
    endtask

    // R6 R10: late and early edges, two samples per bit
    task automatic t_mode2_corr;
        do_reset(1'b1);
        play(1, 14, 1'b0, 200, 18);
        chk("R6", "mode 2 late corr", probe_corr, 1);
        chk("R6", "mode 2 late strobe tick", v1_tick, 187);
        chk("R4", "mode 2 late word", int'(v1_word), 16'hFFFD);
        do_reset(1'b1);
        play(1, 8, 1'b0, 200, 18);
        chk("R6", "mode 2 early corr", probe_corr, -1);
        chk("R6", "mode 2 early strobe tick", v1_tick, 185);
        chk("R4", "mode 2 early word", int'(v1_word), 16'hFFFD);
    endtask

    initial begin
        t_reset;
        t_nominal3;
        t_nrzi;
        t_late3;
        t_early3;
        t_gated;
        t_nominal2;
        t_mode2_corr;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule